// File: doc/BRIEF.md
# Two-Context Priority Interrupt Controller

This block collects level-sensitive interrupt inputs from up to `NUM_SRC` sources and presents them to two targets: context 0 (the machine-mode handler) and context 1 (the supervisor-mode handler). Every source has a small programmable priority. Each context has its own set of enable bits, its own priority threshold and its own claim/complete register.

For each context the block continuously picks the best enabled pending source. That is the one with the highest priority, or the lowest ID when priorities are equal, and it must be strictly above the context's threshold. When such a source exists, the context's interrupt line is raised.

Software runs each interrupt in two steps. It first reads the claim register, which returns the winning ID and removes that source from the pending set in the same access. It then writes the same ID back to complete the interrupt. Between the claim and the completion the source is held in-service, so a level that is still high cannot re-enter the pending set. All registers are reached over a simple single-cycle bus with address, write strobe, read strobe and 32-bit data.

Top module: `intc_core`

## Requirements
- R1: After reset every priority, enable bit, threshold, pending bit and in-service bit is 0. Both `irq_o` bits are low and both claim registers read 0.
- R2: Source s has its priority in the low `PRIO_W` bits of the word at byte address s*4. Source 0 is reserved: its priority always reads 0 and its input never sets a pending bit.
- R3: The enable bit of source s for context c is bit s%32 of the word at 0x2000 + c*0x80 + (s/32)*4. A context never selects a source whose enable bit for that context is 0.
- R4: The pending bits are bit s%32 of the read-only word at 0x1000 + (s/32)*4. A high input on a source that is not in-service sets its pending bit on the next clock edge, whatever the enables say. Writes to these words have no effect.
- R5: A read of the claim register returns the enabled pending source with the highest priority. Among equal priorities the lowest ID wins.
- R6: A source is selected only if its priority is strictly greater than the context threshold. A priority of 0 therefore never interrupts, and when nothing qualifies the claim register returns 0.
- R7: A claim read that returns a nonzero ID clears that source's pending bit and marks it in-service. While it is in-service the source does not become pending again, even if its input stays high.
- R8: Writing an ID to a context's claim register clears that source's in-service mark only if the source is enabled for that context. Otherwise the write is ignored. Once the mark is cleared, a still-high input is pending again one edge later.
- R9: `irq_o[c]` is high, without a clock delay, exactly when context c's claim register would return a nonzero ID. It falls once the claim removes the last qualifying source.
- R10: Context c's threshold sits in the low `PRIO_W` bits at 0x200000 + c*0x1000, and its claim/complete register sits at offset 4 of that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Level interrupt inputs, bit s is source s |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (needed for claim side effect) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_o | output | 2 | Interrupt request per context |

## Verification
A claim or a completion can land in the same cycle as a still-asserted input on the same source, and the result depends on which of the two wins.

The bench holds three inputs high while it claims them one after another. It then reads the pending words to confirm that the claimed sources stayed out of the pending set.

Next it completes one source while that input is still high. The source must reappear as pending exactly one edge later and must be claimable again. A completion sent through the other context, where the source is disabled, must leave it parked in-service.

// File: rtl/intc_core.sv
module intc_core #(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [1:0]         irq_o
);
  localparam int NUM_CTX = 2;
  localparam int ID_W    = $clog2(NUM_SRC);
  localparam int NWORD   = (NUM_SRC + 31) / 32;
  localparam int SRC_PAD = NWORD * 32;
  localparam logic [31:0] PEND_BASE = 32'h0000_1000;
  localparam logic [31:0] EN_BASE   = 32'h0000_2000;
  localparam logic [31:0] CTX_BASE  = 32'h0020_0000;
  localparam logic [31:0] PRIO_END  = 32'(NUM_SRC * 4);
  localparam logic [31:0] PEND_END  = PEND_BASE + 32'(NWORD * 4);
  localparam logic [31:0] EN_END    = EN_BASE + 32'(NUM_CTX * 128);
  localparam logic [31:0] CTX_END   = CTX_BASE + 32'(NUM_CTX * 4096);

  logic [PRIO_W-1:0]       prio [NUM_SRC];
  logic [PRIO_W-1:0]       thr  [NUM_CTX];
  logic [SRC_PAD-1:0]      en   [NUM_CTX];
  logic [SRC_PAD-1:0]      pend, insvc, src_pad, clr_mask, done_mask;
  logic [NUM_CTX*ID_W-1:0] best_flat;

  logic [31:0]     a;
  logic            hit_prio, hit_pend, hit_en, hit_ctx, word_ok;
  logic            at_thr, at_claim, claim_rd, cmpl_wr, cmpl_ok;
  logic [ID_W-1:0] prio_idx, claim_id, cmpl_id;
  logic [4:0]      word;
  logic            en_sel, ctx_sel;

  assign a        = 32'(bus_addr);
  assign hit_prio = a < PRIO_END;
  assign hit_pend = (a >= PEND_BASE) && (a < PEND_END);
  assign hit_en   = (a >= EN_BASE) && (a < EN_END);
  assign hit_ctx  = (a >= CTX_BASE) && (a < CTX_END);
  assign prio_idx = a[ID_W+1:2];
  assign word     = a[6:2];
  assign word_ok  = {27'd0, word} < 32'(NWORD);
  assign en_sel   = a[7];
  assign ctx_sel  = a[12];
  assign at_thr   = hit_ctx && (a[11:0] == 12'h000);
  assign at_claim = hit_ctx && (a[11:0] == 12'h004);

  assign claim_rd = bus_re && !bus_we && at_claim;
  assign cmpl_wr  = bus_we && at_claim;
  assign claim_id = ctx_sel ? best_flat[ID_W +: ID_W] : best_flat[0 +: ID_W];
  assign cmpl_id  = bus_wdata[ID_W-1:0];
  assign cmpl_ok  = (bus_wdata < 32'(NUM_SRC)) && en[ctx_sel][cmpl_id];

  assign clr_mask  = (claim_rd && claim_id != '0) ? (SRC_PAD'(1) << claim_id) : '0;
  assign done_mask = (cmpl_wr && cmpl_ok) ? (SRC_PAD'(1) << cmpl_id) : '0;
  assign src_pad   = SRC_PAD'(src_i) & ~SRC_PAD'(1);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
    logic [ID_W-1:0] id_c;
    always_comb begin
      logic [PRIO_W-1:0] bp;
      bp   = thr[c];
      id_c = '0;
      for (int s = 1; s < NUM_SRC; s++) begin
        if (pend[s] && en[c][s] && prio[s] > bp) begin
          bp   = prio[s];
          id_c = ID_W'(s);
        end
      end
    end
    assign best_flat[c*ID_W +: ID_W] = id_c;
    assign irq_o[c] = id_c != '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_prio)
      bus_rdata = 32'(prio[prio_idx]);
    else if (hit_pend && word_ok)
      bus_rdata = pend[int'(word)*32 +: 32];
    else if (hit_en && word_ok)
      bus_rdata = en[en_sel][int'(word)*32 +: 32];
    else if (at_thr)
      bus_rdata = 32'(thr[ctx_sel]);
    else if (at_claim)
      bus_rdata = 32'(claim_id);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SRC; s++) prio[s] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        thr[c] <= '0;
        en[c]  <= '0;
      end
      pend  <= '0;
      insvc <= '0;
    end else begin
      pend  <= (pend | (src_pad & ~insvc)) & ~clr_mask;
      insvc <= (insvc | clr_mask) & ~done_mask;
      if (bus_we) begin
        if (hit_prio && prio_idx != '0)
          prio[prio_idx] <= bus_wdata[PRIO_W-1:0];
        if (hit_en && word_ok)
          en[en_sel][int'(word)*32 +: 32] <= bus_wdata;
        if (at_thr)
          thr[ctx_sel] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk #(
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 26,
  parameter int SRC_PAD = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic               bus_re,
  input logic [31:0]        bus_rdata,
  input logic [1:0]         irq_o,
  input logic [SRC_PAD-1:0] pend,
  input logic [SRC_PAD-1:0] insvc
);
  localparam int ID_W = $clog2(NUM_SRC);
  logic [31:0]     a;
  logic            claim_now, claim_q;
  logic [ID_W-1:0] id_q;
  logic [SRC_PAD-1:0] src_pad;

  assign a = 32'(bus_addr);
  assign src_pad = SRC_PAD'(src_i);
  assign claim_now = bus_re && !bus_we && (a == 32'h0020_0004 || a == 32'h0020_1004)
                     && bus_rdata != 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim_q <= 1'b0;
      id_q    <= '0;
    end else begin
      claim_q <= claim_now;
      id_q    <= bus_rdata[ID_W-1:0];
    end
  end

  a_r7_claim_moves_to_service: assert property (@(posedge clk) disable iff (!rst_n)
    claim_q |-> (!pend[id_q] && insvc[id_q]));

  a_r7_pend_insvc_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & insvc) == '0);

  a_r2_source0_inert: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0] && !insvc[0]);

  a_r4_pend_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(src_pad)) == '0));

  a_r7_service_only_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    ((insvc & ~$past(insvc)) != '0) |-> $past(bus_re));

  a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != 2'b00) |-> (pend != '0));
endmodule

bind intc_core intc_core_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .SRC_PAD(SRC_PAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .pend(pend), .insvc(insvc)
);

// File: tb/intc_core_tb.sv
module intc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 128;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic [25:0]     bus_addr = '0;
  logic            bus_we = 1'b0;
  logic            bus_re = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [1:0]      irq_o;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_core u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  localparam logic [25:0] PEND0  = 26'h1000;
  localparam logic [25:0] EN0    = 26'h2000;
  localparam logic [25:0] EN1    = 26'h2080;
  localparam logic [25:0] THR0   = 26'h200000;
  localparam logic [25:0] CLAIM0 = 26'h200004;
  localparam logic [25:0] THR1   = 26'h201000;
  localparam logic [25:0] CLAIM1 = 26'h201004;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [25:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [25:0] addr, output logic [31:0] data);
    @(negedge clk);
    bus_addr = addr; bus_re = 1'b1;
    #1 data = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1 check("R1 irq after reset", 32'(irq_o), 32'd0);
    rd(CLAIM0, d); check("R1 claim ctx0", d, 0);
    rd(CLAIM1, d); check("R1 claim ctx1", d, 0);
    rd(PEND0, d);  check("R1 pending word", d, 0);
    rd(26'd20, d); check("R1 priority", d, 0);
    rd(THR1, d);   check("R1 threshold", d, 0);
  endtask

  task automatic t_arbitration;
    logic [31:0] d;
    wr(26'd20, 3); wr(26'd36, 3); wr(26'd160, 6);
    rd(26'd20, d);  check("R2 priority readback", d, 3);
    rd(26'd160, d); check("R2 priority readback 40", d, 6);
    wr(EN0, 32'hFFFF_FFFF); wr(EN0 + 4, 32'hFFFF_FFFF);
    rd(EN0 + 4, d); check("R3 enable readback", d, 32'hFFFF_FFFF);
    @(negedge clk); src_i[5] = 1; src_i[9] = 1; src_i[40] = 1;
    @(negedge clk); #1;
    check("R9 irq ctx0 raised", 32'(irq_o[0]), 1);
    check("R3 ctx1 not enabled", 32'(irq_o[1]), 0);
    rd(PEND0, d); check("R4 pending word0", d, 32'h0000_0220);
    rd(CLAIM0, d); check("R5 highest priority first", d, 40);
    rd(CLAIM0, d); check("R5 tie to lowest id", d, 5);
    rd(CLAIM0, d); check("R5 next tie member", d, 9);
    rd(CLAIM0, d); check("R6 nothing left", d, 0);
    #1 check("R9 irq dropped after last claim", 32'(irq_o[0]), 0);
    rd(PEND0, d);      check("R7 word0 held in service", d, 0);
    rd(PEND0 + 4, d);  check("R7 word1 held in service", d, 0);
  endtask

  task automatic t_complete;
    logic [31:0] d;
    wr(CLAIM0, 5);
    rd(PEND0, d); check("R8 completed source pending again", d, 32'h20);
    rd(CLAIM0, d); check("R8 re-claim", d, 5);
    wr(CLAIM1, 9);
    rd(PEND0, d); check("R8 completion via disabled ctx ignored", d, 0);
    wr(CLAIM0, 9);
    rd(PEND0, d); check("R8 completion via enabled ctx", d, 32'h200);
  endtask

  task automatic t_threshold;
    logic [31:0] d;
    wr(26'd280, 4);
    wr(EN1 + 8, 32'h40);
    wr(THR1, 4);
    rd(THR1, d); check("R10 threshold readback", d, 4);
    @(negedge clk); src_i[70] = 1;
    @(negedge clk); #1;
    check("R6 equal to threshold masked", 32'(irq_o[1]), 0);
    rd(CLAIM1, d); check("R6 claim under threshold", d, 0);
    rd(PEND0 + 8, d); check("R4 pending despite mask", d, 32'h40);
    wr(THR1, 3);
    #1 check("R6 above threshold interrupts", 32'(irq_o[1]), 1);
    rd(CLAIM1, d); check("R10 claim ctx1", d, 70);
    wr(EN1 + 12, 32'h10);
    wr(THR1, 0);
    @(negedge clk); src_i[100] = 1;
    @(negedge clk);
    rd(PEND0 + 12, d); check("R4 prio0 source pending", d, 32'h10);
    rd(CLAIM1, d); check("R6 priority 0 never claimed", d, 0);
    wr(PEND0 + 12, 0);
    rd(PEND0 + 12, d); check("R4 pending is read-only", d, 32'h10);
  endtask

  task automatic t_source0;
    logic [31:0] d;
    wr(26'd0, 7);
    rd(26'd0, d); check("R2 source0 priority fixed", d, 0);
    @(negedge clk); src_i[0] = 1;
    @(negedge clk);
    rd(PEND0, d); check("R2 source0 never pending", d & 32'h1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_arbitration();
    t_complete();
    t_threshold();
    t_source0();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule